// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block holds the fetch address of a small 4-bit controller whose program store has 12-bit words. The address is split into a one-bit bank, a four-bit page and an eight-bit step. Each clock cycle the decoder raises at most one strobe, and that strobe names the instruction that finishes in that cycle. The block turns the strobe into the next fetch address. Straight-line code only moves the step, so it stays inside the current 256-word page.

A page-set instruction writes a pending bank/page pair. Only the branch that comes directly after it can use that pair. Any other instruction reloads the pair from the address the sequencer has just reached, so a jump that does not follow a page-set lands inside its own page. The block also outputs the return address for the stack, as three nibbles, and it takes the popped address back on a return. The stack memory, the ALU and the instruction decoder are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `fetch_addr` is bank 0, page 1, step 0x00, which is 13'h0100. Bit 12 is the bank, bits 11:8 are the page and bits 7:0 are the step.
- R2: A cycle with no strobe leaves `fetch_addr` unchanged. It also leaves the pending bank/page pair unchanged, so a page-set followed by idle cycles still redirects the next branch.
- R3: An advance adds one to the step modulo 256. The bank and page stay the same, so step 0xFF wraps to 0x00 in the same page.
- R4: A page-set advances the step like R3. It also loads the pending pair from `operand[4:0]`: bit 4 becomes the bank and bits 3:0 become the page.
- R5: A jump (`op_jp`) in the instruction directly after a page-set goes to the pending bank and page, with the step taken from `operand`.
- R6: A jump with any other instruction before it (including an advance that comes after a page-set) keeps the current bank and page and takes the step from `operand`.
- R7: `op_jc` is taken when `flag_c`=1, `op_jnc` when `flag_c`=0, `op_jz` when `flag_z`=1 and `op_jnz` when `flag_z`=0. A taken branch acts as in R5/R6. A branch that is not taken advances as in R3.
- R8: A call goes to its target as in R5/R6. While `op_call` is high, `push_addr` shows the current page in bits 11:8 and the current step plus one (modulo 256) in bits 7:0.
- R9: A call-to-page-zero goes to page 0 of the current bank, with the step from `operand`, and ignores any pending pair. `push_addr` behaves as in R8.
- R10: A return keeps the bank. It loads the page from `pop_addr[11:8]` and the step from `pop_addr[7:0]`.
- R11: An indirect jump takes its bank and page as in R5/R6 and its step from `operand`, which carries the register-pair value.
- R12: When several strobes are high in one cycle, only one acts. The order, from first to last, is: return, indirect jump, call, call-to-page-zero, jump, conditional jumps (carry set, carry clear, zero set, zero clear), page-set, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_adv | input | 1 | Sequential advance strobe |
| op_pset | input | 1 | Page-set strobe |
| op_jp | input | 1 | Unconditional jump strobe |
| op_jc | input | 1 | Jump if carry set |
| op_jnc | input | 1 | Jump if carry clear |
| op_jz | input | 1 | Jump if zero set |
| op_jnz | input | 1 | Jump if zero clear |
| op_call | input | 1 | Call strobe |
| op_calz | input | 1 | Call-to-page-zero strobe |
| op_ret | input | 1 | Return strobe |
| op_jind | input | 1 | Indirect jump strobe |
| operand | input | 8 | Immediate step, register-pair value, or page-set argument in bits 4:0 |
| pop_addr | input | 12 | Page and step popped from the stack |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| fetch_addr | output | 13 | Registered fetch address {bank, page, step} |
| push_addr | output | 12 | Return address nibbles {page, step+1} |

## Verification
A scoreboard drives the strobe patterns and checks each result. Jumps come in three settings: right after a page-set, after a page-set with an idle gap, and after a page-set with an advance in between. Together these show whether the pending pair lives exactly one instruction. Every conditional branch runs once with its flag true and once with it false, which separates taken from fall-through for each of the four tests. Calls and call-to-page-zero run with different pending pages, so the forced page 0 can be told apart, and one call sits at step 0xFF to check that the pushed step wraps. A cycle with return, indirect jump and advance all high checks the priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    parameter int BANK_W   = 1;
    parameter int PAGE_W   = 4;
    parameter int STEP_W   = 8;
    parameter int RST_PAGE = 1;
    localparam int ADDR_W  = BANK_W + PAGE_W + STEP_W;
    localparam int RET_W   = PAGE_W + STEP_W;
    localparam int PSEL_W  = BANK_W + PAGE_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
        logic [STEP_W-1:0] step;
    } pc_t;

    typedef struct packed {
        logic adv;
        logic pset;
        logic jp;
        logic jc;
        logic jnc;
        logic jz;
        logic jnz;
        logic call;
        logic calz;
        logic ret;
        logic jind;
    } op_t;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_NEXT,
        SEL_FAR,
        SEL_ZERO,
        SEL_RET
    } sel_e;
endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
(
    input  op_t  ops,
    input  logic flag_c,
    input  logic flag_z,
    output sel_e sel,
    output logic load_ptr,
    output logic is_instr
);
    always_comb begin
        sel      = SEL_HOLD;
        load_ptr = 1'b0;
        if (ops.ret)        sel = SEL_RET;
        else if (ops.jind)  sel = SEL_FAR;
        else if (ops.call)  sel = SEL_FAR;
        else if (ops.calz)  sel = SEL_ZERO;
        else if (ops.jp)    sel = SEL_FAR;
        else if (ops.jc)    sel = flag_c  ? SEL_FAR : SEL_NEXT;
        else if (ops.jnc)   sel = !flag_c ? SEL_FAR : SEL_NEXT;
        else if (ops.jz)    sel = flag_z  ? SEL_FAR : SEL_NEXT;
        else if (ops.jnz)   sel = !flag_z ? SEL_FAR : SEL_NEXT;
        else if (ops.pset) begin
            sel      = SEL_NEXT;
            load_ptr = 1'b1;
        end
        else if (ops.adv)   sel = SEL_NEXT;
        is_instr = (sel != SEL_HOLD);
    end
endmodule

// File: rtl/pcseq_ptr.sv
module pcseq_ptr
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ptr,
    input  logic              is_instr,
    input  logic [PSEL_W-1:0] arg,
    input  logic [BANK_W-1:0] cur_bank_d,
    input  logic [PAGE_W-1:0] cur_page_d,
    output logic [BANK_W-1:0] nb_q,
    output logic [PAGE_W-1:0] np_q
);
    typedef struct packed {
        logic [BANK_W-1:0] nb;
        logic [PAGE_W-1:0] np;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_ptr) begin
            ptr_d.nb = arg[PSEL_W-1 -: BANK_W];
            ptr_d.np = arg[PAGE_W-1:0];
        end else if (is_instr) begin
            ptr_d.nb = cur_bank_d;
            ptr_d.np = cur_page_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q.nb <= '0;
            ptr_q.np <= PAGE_W'(RST_PAGE);
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign nb_q = ptr_q.nb;
    assign np_q = ptr_q.np;

    // R4: the pending pair captures the page-set argument
    a_r4_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_ptr |=> ({nb_q, np_q} == $past(arg)));

    // R2: idle cycles leave the pending pair alone
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_instr |=> ($stable(nb_q) && $stable(np_q)));
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
(
    input  pc_t               pc_q,
    input  sel_e              sel,
    input  logic [BANK_W-1:0] nb_q,
    input  logic [PAGE_W-1:0] np_q,
    input  logic [STEP_W-1:0] operand,
    input  logic [RET_W-1:0]  pop_addr,
    output pc_t               pc_d,
    output logic [RET_W-1:0]  push_addr
);
    logic [STEP_W-1:0] step_inc;

    always_comb begin
        step_inc = pc_q.step + STEP_W'(1);
        pc_d     = pc_q;
        case (sel)
            SEL_NEXT: pc_d.step = step_inc;
            SEL_FAR: begin
                pc_d.bank = nb_q;
                pc_d.page = np_q;
                pc_d.step = operand;
            end
            SEL_ZERO: begin
                pc_d.page = '0;
                pc_d.step = operand;
            end
            SEL_RET: begin
                pc_d.page = pop_addr[RET_W-1:STEP_W];
                pc_d.step = pop_addr[STEP_W-1:0];
            end
            default: pc_d = pc_q;
        endcase
        push_addr = {pc_q.page, step_inc};
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_adv,
    input  logic              op_pset,
    input  logic              op_jp,
    input  logic              op_jc,
    input  logic              op_jnc,
    input  logic              op_jz,
    input  logic              op_jnz,
    input  logic              op_call,
    input  logic              op_calz,
    input  logic              op_ret,
    input  logic              op_jind,
    input  logic [STEP_W-1:0] operand,
    input  logic [RET_W-1:0]  pop_addr,
    input  logic              flag_c,
    input  logic              flag_z,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [RET_W-1:0]  push_addr
);
    op_t               ops;
    sel_e              sel;
    logic              load_ptr;
    logic              is_instr;
    logic [BANK_W-1:0] nb_q;
    logic [PAGE_W-1:0] np_q;
    pc_t               pc_d, pc_q;

    always_comb begin
        ops.adv  = op_adv;
        ops.pset = op_pset;
        ops.jp   = op_jp;
        ops.jc   = op_jc;
        ops.jnc  = op_jnc;
        ops.jz   = op_jz;
        ops.jnz  = op_jnz;
        ops.call = op_call;
        ops.calz = op_calz;
        ops.ret  = op_ret;
        ops.jind = op_jind;
    end

    pcseq_cond u_cond (
        .ops      (ops),
        .flag_c   (flag_c),
        .flag_z   (flag_z),
        .sel      (sel),
        .load_ptr (load_ptr),
        .is_instr (is_instr)
    );

    pcseq_ptr u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_ptr   (load_ptr),
        .is_instr   (is_instr),
        .arg        (operand[PSEL_W-1:0]),
        .cur_bank_d (pc_d.bank),
        .cur_page_d (pc_d.page),
        .nb_q       (nb_q),
        .np_q       (np_q)
    );

    pcseq_target u_tgt (
        .pc_q      (pc_q),
        .sel       (sel),
        .nb_q      (nb_q),
        .np_q      (np_q),
        .operand   (operand),
        .pop_addr  (pop_addr),
        .pc_d      (pc_d),
        .push_addr (push_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q.bank <= '0;
            pc_q.page <= PAGE_W'(RST_PAGE);
            pc_q.step <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign fetch_addr = pc_q;

    // ---------------- checker state and assertions ----------------
    logic              single;
    logic              after_pset_q;
    logic [PSEL_W-1:0] pset_arg_q;

    assign single = ($countones(ops) == 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            after_pset_q <= 1'b0;
            pset_arg_q   <= '0;
        end else if (ops != '0) begin
            after_pset_q <= single && op_pset;
            if (single && op_pset) pset_arg_q <= operand[PSEL_W-1:0];
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ops == '0) |=> $stable(fetch_addr));

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (single && op_adv) |=>
            (fetch_addr[STEP_W-1:0] == STEP_W'($past(fetch_addr[STEP_W-1:0]) + 1'b1))
            && $stable(fetch_addr[ADDR_W-1:STEP_W]));

    a_r5_far_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (single && op_jp && after_pset_q) |=>
            (fetch_addr == {$past(pset_arg_q), $past(operand)}));

    a_r6_local_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (single && op_jp && !after_pset_q) |=>
            (fetch_addr == {$past(fetch_addr[ADDR_W-1:STEP_W]), $past(operand)}));

    a_r7_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (single && ((op_jc && !flag_c) || (op_jz && !flag_z))) |=>
            (fetch_addr[STEP_W-1:0] == STEP_W'($past(fetch_addr[STEP_W-1:0]) + 1'b1)));

    a_r9_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (single && op_calz) |=>
            ((fetch_addr[STEP_W +: PAGE_W] == '0) && $stable(fetch_addr[ADDR_W-1 -: BANK_W])));

    // R10 and R12: a return wins over every other strobe
    a_r12_ret_first: assert property (@(posedge clk) disable iff (!rst_n)
        op_ret |=> ((fetch_addr[RET_W-1:0] == $past(pop_addr))
                    && $stable(fetch_addr[ADDR_W-1 -: BANK_W])));
endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    localparam int B_ADV  = 0;
    localparam int B_PSET = 1;
    localparam int B_JP   = 2;
    localparam int B_JC   = 3;
    localparam int B_JNC  = 4;
    localparam int B_JZ   = 5;
    localparam int B_JNZ  = 6;
    localparam int B_CALL = 7;
    localparam int B_CALZ = 8;
    localparam int B_RET  = 9;
    localparam int B_JIND = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ops = '0;
    logic [7:0]  operand = '0;
    logic [11:0] pop_addr = '0;
    logic        flag_c = 1'b0;
    logic        flag_z = 1'b0;
    logic [12:0] fetch_addr;
    logic [11:0] push_addr;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [12:0] addr;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    logic       mb, nb;
    logic [3:0] mp, np;
    logic [7:0] ms;

    always #2 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst_n(rst_n),
        .op_adv(ops[B_ADV]), .op_pset(ops[B_PSET]), .op_jp(ops[B_JP]),
        .op_jc(ops[B_JC]), .op_jnc(ops[B_JNC]), .op_jz(ops[B_JZ]),
        .op_jnz(ops[B_JNZ]), .op_call(ops[B_CALL]), .op_calz(ops[B_CALZ]),
        .op_ret(ops[B_RET]), .op_jind(ops[B_JIND]),
        .operand(operand), .pop_addr(pop_addr),
        .flag_c(flag_c), .flag_z(flag_z),
        .fetch_addr(fetch_addr), .push_addr(push_addr)
    );

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares the registered address half a cycle after each edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, fetch_addr, e.addr);
        end
    end

    // driver: applies one cycle of strobes and queues the expected address
    task automatic drive(input logic [10:0] o, input logic [7:0] opr,
                         input logic [11:0] pop, input logic c, input logic z,
                         input string req);
        logic       far, zero, ret, next, ld;
        logic       tb_b;
        logic [3:0] tb_p;
        logic [7:0] tb_s;
        exp_t       e;
        @(negedge clk);
        ops = o; operand = opr; pop_addr = pop; flag_c = c; flag_z = z;
        far = 0; zero = 0; ret = 0; next = 0; ld = 0;
        if (o[B_RET])       ret  = 1;
        else if (o[B_JIND]) far  = 1;
        else if (o[B_CALL]) far  = 1;
        else if (o[B_CALZ]) zero = 1;
        else if (o[B_JP])   far  = 1;
        else if (o[B_JC])   begin far = c;  next = !c; end
        else if (o[B_JNC])  begin far = !c; next = c;  end
        else if (o[B_JZ])   begin far = z;  next = !z; end
        else if (o[B_JNZ])  begin far = !z; next = z;  end
        else if (o[B_PSET]) begin next = 1; ld = 1; end
        else if (o[B_ADV])  next = 1;
        tb_b = mb; tb_p = mp; tb_s = ms;
        if (ret)       begin tb_p = pop[11:8]; tb_s = pop[7:0]; end
        else if (far)  begin tb_b = nb; tb_p = np; tb_s = opr; end
        else if (zero) begin tb_p = 4'h0; tb_s = opr; end
        else if (next) tb_s = ms + 8'd1;
        if ((o[B_CALL] || o[B_CALZ]) && !o[B_RET] && !o[B_JIND]) begin
            #1;
            check({req, " push"}, {1'b0, push_addr}, {1'b0, mp, 8'(ms + 8'd1)});
        end
        if (ld) begin nb = opr[4]; np = opr[3:0]; end
        else if (ret || far || zero || next) begin nb = tb_b; np = tb_p; end
        mb = tb_b; mp = tb_p; ms = tb_s;
        @(posedge clk);
        #1;
        ops = '0;
        e.addr = {mb, mp, ms};
        e.req  = req;
        exp_q.push_back(e);
    endtask

    function automatic logic [10:0] one(input int b);
        return 11'(1) << b;
    endfunction

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        mb = 0; mp = 4'h1; ms = 8'h00; nb = 0; np = 4'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", fetch_addr, 13'h0100);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", fetch_addr, 13'h0100);

        repeat (3) drive(one(B_ADV), 8'h00, 12'h000, 0, 0, "R3 advance");
        drive('0, 8'h00, 12'h000, 0, 0, "R2 idle");
        drive('0, 8'h55, 12'h000, 1, 1, "R2 idle");
        drive(one(B_JP), 8'hFE, 12'h000, 0, 0, "R6 local jump");
        drive(one(B_ADV), 8'h00, 12'h000, 0, 0, "R3 advance");
        drive(one(B_ADV), 8'h00, 12'h000, 0, 0, "R3 wrap");
        drive(one(B_PSET), 8'h13, 12'h000, 0, 0, "R4 page-set");
        drive('0, 8'h00, 12'h000, 0, 0, "R2 idle keeps pending");
        drive(one(B_JP), 8'h40, 12'h000, 0, 0, "R5 far jump");
        drive(one(B_PSET), 8'h05, 12'h000, 0, 0, "R4 page-set");
        drive(one(B_ADV), 8'h00, 12'h000, 0, 0, "R3 advance");
        drive(one(B_JP), 8'h22, 12'h000, 0, 0, "R6 stale page-set");
        drive(one(B_JC),  8'h99, 12'h000, 0, 0, "R7 jc not taken");
        drive(one(B_JC),  8'h10, 12'h000, 1, 0, "R7 jc taken");
        drive(one(B_JNC), 8'h99, 12'h000, 1, 0, "R7 jnc not taken");
        drive(one(B_JNC), 8'h80, 12'h000, 0, 0, "R7 jnc taken");
        drive(one(B_JZ),  8'h05, 12'h000, 0, 1, "R7 jz taken");
        drive(one(B_JZ),  8'h99, 12'h000, 0, 0, "R7 jz not taken");
        drive(one(B_JNZ), 8'hA0, 12'h000, 0, 0, "R7 jnz taken");
        drive(one(B_JNZ), 8'h99, 12'h000, 0, 1, "R7 jnz not taken");
        drive(one(B_PSET), 8'h0A, 12'h000, 0, 0, "R4 page-set");
        drive(one(B_JC),  8'h33, 12'h000, 1, 0, "R7 far conditional");
        drive(one(B_PSET), 8'h1E, 12'h000, 0, 0, "R4 page-set");
        drive(one(B_CALL), 8'h44, 12'h000, 0, 0, "R8 call");
        drive(one(B_PSET), 8'h07, 12'h000, 0, 0, "R4 page-set");
        drive(one(B_CALZ), 8'h12, 12'h000, 0, 0, "R9 call page zero");
        drive(one(B_RET), 8'h00, 12'hA35, 0, 0, "R10 return");
        drive(one(B_PSET), 8'h02, 12'h000, 0, 0, "R4 page-set");
        drive(one(B_JIND), 8'h77, 12'h000, 0, 0, "R11 indirect far");
        drive(one(B_JIND), 8'h99, 12'h000, 0, 0, "R11 indirect local");
        drive(one(B_RET) | one(B_JIND) | one(B_ADV), 8'h31, 12'h5F0, 0, 0, "R12 return wins");
        drive(one(B_JIND) | one(B_JP) | one(B_PSET), 8'h1C, 12'h000, 0, 0, "R12 indirect over page-set");
        drive(one(B_JP), 8'hFF, 12'h000, 0, 0, "R6 local jump");
        drive(one(B_CALL), 8'h10, 12'h000, 0, 0, "R8 call at step FF");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule